// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address plus a set of granted access rights, or into a fault code. A translation begins with a one-cycle start strobe that carries the virtual address, the requested rights, the privilege index, a physical-mode flag and the root table base. Two shortcuts finish without touching memory. In physical mode the address passes through unchanged. A kernel superpage window maps part of the negative address half directly and moves one address bit. Every other legal address goes through a walk of up to three table levels. Each level issues one 64-bit read on a valid/ready request port and receives a single response word.

The last-level entry supplies the page frame, the read and write enables for each privilege, and three fault-on-operation bits. These bits take away rights that the enables had already granted. The result comes out with a one-cycle done strobe. The walker handles one translation at a time, and a start strobe that arrives while a walk is in progress is dropped.

Top module: `xw_walker`

## Requirements
- R1: With the physical-mode flag set, done rises one cycle after start with success, a physical address equal to the virtual address, rights 3'b111, and no memory read. The rights and access encoding is bit 0 read, bit 1 write, bit 2 execute.
- R2: When physical mode is off and bits [63:43] of the address are not all equal, the result is an access violation with no memory read. Fault codes are: translation-not-valid 0, access violation 1, fault-on-read 2, fault-on-execute 3, fault-on-write 4.
- R3: An address with bit 63 set and bits [42:41] equal to 2'b10 is a superpage hit and issues no read. At kernel privilege (index 0) the result is success, with a physical address made of virtual bits [39:0] plus virtual bit 40 placed at physical bit 43, and rights 3'b111. At user privilege (index 1) the result is an access violation.
- R4: For level n of 1..3 the read address is table_base + index*8. The index is 10 bits taken from virtual bit 13+10*(3-n). Level 1 uses the root base. Each later base is entry bits [63:32] shifted left by 13.
- R5: At level 1 or 2, an entry with bit 0 (valid) clear ends the walk with translation-not-valid. An entry with bit 8 (kernel read) clear ends it with an access violation. No further read is issued in either case.
- R6: A level-3 entry with the valid bit clear gives translation-not-valid after exactly three reads.
- R7: In a level-3 entry, read and execute are granted by bit 8+priv and write by bit 12+priv. If at least one right was requested and none of them is granted, the result is an access violation.
- R8: Entry bits 1, 2 and 3 remove the read, write and execute rights respectively. If afterwards no requested right remains, the fault is fault-on-execute when execute was requested, otherwise fault-on-write when write was requested, otherwise fault-on-read.
- R9: A successful walk reports the frame (bits [63:32] shifted left by 13) ORed with virtual bits [12:0], and the rights left after masking. A request with no rights asked succeeds.
- R10: A start strobe is ignored while busy is high. The read request holds its valid and address until ready is seen, and done lasts one cycle per translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a translation (sampled while idle) |
| vaddr_i | input | 64 | Virtual address |
| acc_i | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| priv_i | input | 1 | Privilege index: 0 kernel, 1 user |
| phys_i | input | 1 | Physical-mode flag |
| table_base_i | input | 64 | Root table base address |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Table read request accepted |
| mem_req_addr_o | output | 64 | Table entry byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Table entry word |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | Translation succeeded |
| fault_o | output | 3 | Fault code when ok_o is low |
| paddr_o | output | 64 | Physical address when ok_o is high |
| perm_o | output | 3 | Granted rights when ok_o is high |
| busy_o | output | 1 | A walk is in progress |

## Verification
A new start strobe can arrive in the same cycle as a table response that the ongoing walk is still consuming. The walker must finish the walk and drop the new request without a trace. The bench provokes this by waiting for the first response word of a three-level walk and raising start in that cycle with physical mode set, which would produce a result at once if it were taken. The scoreboard holds only the walk's expected result, and it counts any extra done strobe, any change to the walk's result, or any extra table read as a failure.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int XW_VA_BITS   = 43;
    localparam int XW_PAGE_BITS = 13;
    localparam int XW_IDX_BITS  = 10;
    localparam int XW_LEVELS    = 3;
    localparam int XW_LVL_W     = $clog2(XW_LEVELS);
    localparam int XW_ADDR_W    = 64;

    // entry bit positions
    localparam int PTE_VLD  = 0;
    localparam int PTE_FOR  = 1;
    localparam int PTE_FOW  = 2;
    localparam int PTE_FOE  = 3;
    localparam int PTE_KRD  = 8;
    localparam int PTE_KWR  = 12;

    // rights bits
    localparam int ACC_RD = 0;
    localparam int ACC_WR = 1;
    localparam int ACC_EX = 2;

    typedef enum logic [2:0] {
        FLT_TNV = 3'd0,
        FLT_ACV = 3'd1,
        FLT_FOR = 3'd2,
        FLT_FOE = 3'd3,
        FLT_FOW = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } wstate_e;

    typedef struct packed {
        wstate_e                 st;
        logic [XW_LVL_W-1:0]     lvl;
        logic [XW_ADDR_W-1:0]    va;
        logic [2:0]              need;
        logic                    priv;
        logic [XW_ADDR_W-1:0]    base;
        logic                    done;
        logic                    ok;
        logic [2:0]              fault;
        logic [XW_ADDR_W-1:0]    pa;
        logic [2:0]              perm;
    } walk_regs_t;
endpackage

// File: rtl/xw_precheck.sv
module xw_precheck
    import xw_pkg::*;
#(
    parameter int VA_BITS = XW_VA_BITS
) (
    input  logic [XW_ADDR_W-1:0] va_i,
    input  logic                 priv_i,
    input  logic                 phys_i,
    output logic                 hit_o,
    output logic                 ok_o,
    output logic [2:0]           fault_o,
    output logic [XW_ADDR_W-1:0] pa_o,
    output logic [2:0]           perm_o
);
    localparam int SP_SEL_LO = VA_BITS - 2;   // window selector bits
    localparam int SP_SRC    = VA_BITS - 3;   // bit that is relocated
    localparam int SP_DST    = VA_BITS;       // its new position
    localparam int HI_W      = XW_ADDR_W - VA_BITS;

    logic canon, window;

    always_comb begin
        canon  = (va_i[XW_ADDR_W-1:VA_BITS] == {HI_W{va_i[XW_ADDR_W-1]}});
        window = va_i[XW_ADDR_W-1] && (va_i[SP_SEL_LO+1:SP_SEL_LO] == 2'b10);
        hit_o   = 1'b0;
        ok_o    = 1'b0;
        fault_o = FLT_ACV;
        pa_o    = '0;
        perm_o  = '0;
        if (phys_i) begin
            hit_o  = 1'b1;
            ok_o   = 1'b1;
            pa_o   = va_i;
            perm_o = 3'b111;
        end else if (!canon) begin
            hit_o   = 1'b1;
            fault_o = FLT_ACV;
        end else if (window) begin
            hit_o = 1'b1;
            if (priv_i) begin
                fault_o = FLT_ACV;
            end else begin
                ok_o               = 1'b1;
                pa_o[SP_SRC-1:0]   = va_i[SP_SRC-1:0];
                pa_o[SP_DST]       = va_i[SP_SRC];
                perm_o             = 3'b111;
            end
        end
        if (ok_o) fault_o = '0;
    end
endmodule

// File: rtl/xw_index.sv
module xw_index
    import xw_pkg::*;
#(
    parameter int PAGE_BITS = XW_PAGE_BITS,
    parameter int IDX_BITS  = XW_IDX_BITS,
    parameter int LEVELS    = XW_LEVELS
) (
    input  logic [XW_ADDR_W-1:0] va_i,
    input  logic [XW_LVL_W-1:0]  lvl_i,
    output logic [XW_ADDR_W-1:0] off_o
);
    localparam int ENTRY_SHIFT = 3;

    logic [IDX_BITS-1:0] idx_lvl [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign idx_lvl[g] = va_i[PAGE_BITS + IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
    end

    logic [IDX_BITS-1:0] sel;
    always_comb begin
        sel = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (lvl_i == XW_LVL_W'(k)) sel = idx_lvl[k];
        end
        off_o = XW_ADDR_W'(sel) << ENTRY_SHIFT;
    end

    logic unused_va_bits;
    assign unused_va_bits = ^{va_i[XW_ADDR_W-1:PAGE_BITS+IDX_BITS*LEVELS], va_i[PAGE_BITS-1:0]};
endmodule

// File: rtl/xw_pte_eval.sv
module xw_pte_eval
    import xw_pkg::*;
#(
    parameter int PAGE_BITS = XW_PAGE_BITS
) (
    input  logic [63:0]          pte_i,
    input  logic                 last_i,
    input  logic [2:0]           need_i,
    input  logic                 priv_i,
    output logic                 stop_o,
    output logic                 ok_o,
    output logic [2:0]           fault_o,
    output logic [2:0]           perm_o,
    output logic [XW_ADDR_W-1:0] next_base_o
);
    logic       rd_en, wr_en;
    logic [2:0] granted, kept;

    always_comb begin
        next_base_o = XW_ADDR_W'(pte_i[63:32]) << PAGE_BITS;
        rd_en   = priv_i ? pte_i[PTE_KRD+1] : pte_i[PTE_KRD];
        wr_en   = priv_i ? pte_i[PTE_KWR+1] : pte_i[PTE_KWR];
        granted = '0;
        granted[ACC_RD] = rd_en;
        granted[ACC_EX] = rd_en;
        granted[ACC_WR] = wr_en;
        kept    = granted & ~{pte_i[PTE_FOE], pte_i[PTE_FOW], pte_i[PTE_FOR]};
        stop_o  = 1'b1;
        ok_o    = 1'b0;
        fault_o = FLT_ACV;
        perm_o  = '0;
        if (!pte_i[PTE_VLD]) begin
            fault_o = FLT_TNV;
        end else if (!last_i) begin
            if (pte_i[PTE_KRD]) stop_o = 1'b0;
            else                fault_o = FLT_ACV;
        end else if ((need_i != 3'b000) && ((granted & need_i) == 3'b000)) begin
            fault_o = FLT_ACV;
        end else if ((need_i != 3'b000) && ((kept & need_i) == 3'b000)) begin
            if (need_i[ACC_EX])      fault_o = FLT_FOE;
            else if (need_i[ACC_WR]) fault_o = FLT_FOW;
            else                     fault_o = FLT_FOR;
        end else begin
            ok_o    = 1'b1;
            fault_o = '0;
            perm_o  = kept;
        end
    end

    logic unused_pte_bits;
    assign unused_pte_bits = ^{pte_i[31:14], pte_i[11:10], pte_i[7:4]};
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int VA_BITS   = XW_VA_BITS,
    parameter int PAGE_BITS = XW_PAGE_BITS,
    parameter int IDX_BITS  = XW_IDX_BITS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] vaddr_i,
    input  logic [2:0]  acc_i,
    input  logic        priv_i,
    input  logic        phys_i,
    input  logic [63:0] table_base_i,
    output logic        mem_req_valid_o,
    input  logic        mem_req_ready_i,
    output logic [63:0] mem_req_addr_o,
    input  logic        mem_rsp_valid_i,
    input  logic [63:0] mem_rsp_data_i,
    output logic        done_o,
    output logic        ok_o,
    output logic [2:0]  fault_o,
    output logic [63:0] paddr_o,
    output logic [2:0]  perm_o,
    output logic        busy_o
);
    localparam logic [XW_LVL_W-1:0]  LAST_LVL = XW_LVL_W'(XW_LEVELS - 1);
    localparam logic [XW_ADDR_W-1:0] PG_MASK  = (XW_ADDR_W'(1) << PAGE_BITS) - 1;

    walk_regs_t q, d;

    logic                 pre_hit, pre_ok;
    logic [2:0]           pre_fault, pre_perm;
    logic [XW_ADDR_W-1:0] pre_pa;

    logic [XW_ADDR_W-1:0] entry_off;

    logic                 ev_stop, ev_ok;
    logic [2:0]           ev_fault, ev_perm;
    logic [XW_ADDR_W-1:0] ev_next_base;

    xw_precheck #(.VA_BITS(VA_BITS)) u_pre (
        .va_i    (vaddr_i),
        .priv_i  (priv_i),
        .phys_i  (phys_i),
        .hit_o   (pre_hit),
        .ok_o    (pre_ok),
        .fault_o (pre_fault),
        .pa_o    (pre_pa),
        .perm_o  (pre_perm)
    );

    xw_index #(.PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .LEVELS(XW_LEVELS)) u_idx (
        .va_i  (q.va),
        .lvl_i (q.lvl),
        .off_o (entry_off)
    );

    xw_pte_eval #(.PAGE_BITS(PAGE_BITS)) u_ev (
        .pte_i       (mem_rsp_data_i),
        .last_i      (q.lvl == LAST_LVL),
        .need_i      (q.need),
        .priv_i      (q.priv),
        .stop_o      (ev_stop),
        .ok_o        (ev_ok),
        .fault_o     (ev_fault),
        .perm_o      (ev_perm),
        .next_base_o (ev_next_base)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.va   = vaddr_i;
                    d.need = acc_i;
                    d.priv = priv_i;
                    d.lvl  = '0;
                    d.base = table_base_i;
                    if (pre_hit) begin
                        d.done  = 1'b1;
                        d.ok    = pre_ok;
                        d.fault = pre_fault;
                        d.pa    = pre_pa;
                        d.perm  = pre_perm;
                    end else begin
                        d.st = S_REQ;
                    end
                end
            end
            S_REQ: begin
                if (mem_req_ready_i) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (ev_stop) begin
                        d.st    = S_IDLE;
                        d.done  = 1'b1;
                        d.ok    = ev_ok;
                        d.fault = ev_fault;
                        d.perm  = ev_perm;
                        d.pa    = ev_ok ? (ev_next_base | (q.va & PG_MASK)) : '0;
                    end else begin
                        d.lvl  = q.lvl + 1'b1;
                        d.base = ev_next_base;
                        d.st   = S_REQ;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_valid_o = (q.st == S_REQ);
    assign mem_req_addr_o  = q.base + entry_off;
    assign done_o          = q.done;
    assign ok_o            = q.ok;
    assign fault_o         = q.fault;
    assign paddr_o         = q.pa;
    assign perm_o          = q.perm;
    assign busy_o          = (q.st != S_IDLE);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    assert_start_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(q.need) && $stable(q.va));

    assert_fault_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !ok_o |-> fault_o <= 3'd4);

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> q.lvl <= LAST_LVL);

    assert_ok_has_need_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT) && mem_rsp_valid_i && ev_ok && (q.need != 3'b000)
        |=> done_o && ok_o && ((perm_o & q.need) != 3'b000));

    assert_early_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i && pre_hit |=> !mem_req_valid_o && done_o);
endmodule

// File: tb/sim_xw_walker.sv
module sim_xw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] vaddr_i = '0;
    logic [2:0]  acc_i = '0;
    logic        priv_i = 1'b0;
    logic        phys_i = 1'b0;
    logic [63:0] table_base_i = '0;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [63:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = '0;
    logic        done_o, ok_o, busy_o;
    logic [2:0]  fault_o, perm_o;
    logic [63:0] paddr_o;

    always #5 clk = ~clk;

    xw_walker u0 (.*);

    typedef struct {
        logic        ok;
        logic [2:0]  fault;
        logic [63:0] pa;
        logic [2:0]  perm;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, failures = 0, seen = 0, reads = 0, cyc = 0;
    bit finished = 0;

    logic [63:0] mem [logic [63:0]];

    localparam logic [63:0] V = 64'h1, FR = 64'h2, FW = 64'h4, FE = 64'h8;
    localparam logic [63:0] KR = 64'h100, UR = 64'h200, KW = 64'h1000, UW = 64'h2000;

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // memory responder with irregular ready
    logic [7:0]  lfsr = 8'h5A;
    logic        pend = 1'b0;
    logic [63:0] pend_addr = '0;
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready_i <= lfsr[0] | lfsr[3];
        mem_rsp_valid_i <= 1'b0;
        if (pend) begin
            mem_rsp_valid_i <= 1'b1;
            mem_rsp_data_i  <= rd(pend_addr);
            pend <= 1'b0;
        end
        if (mem_req_valid_o && mem_req_ready_i) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr_o;
            reads     <= reads + 1;
        end
    end

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected done", 64'(done_o), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ok_o == e.ok, e.tag, "ok", 64'(ok_o), 64'(e.ok));
                if (e.ok) begin
                    check(paddr_o == e.pa, e.tag, "paddr", paddr_o, e.pa);
                    check(perm_o == e.perm, e.tag, "perm", 64'(perm_o), 64'(e.perm));
                end else begin
                    check(fault_o == e.fault, e.tag, "fault", 64'(fault_o), 64'(e.fault));
                end
            end
            seen++;
        end
    end

    // independent model from the requirements
    task automatic model(input logic [63:0] va, input logic [2:0] need, input logic priv,
                         input logic phys, input logic [63:0] base,
                         output exp_t e, output int n);
        logic [63:0] tb, pte;
        logic [2:0]  g, k;
        e.ok = 0; e.fault = 3'd1; e.pa = '0; e.perm = '0; n = 0;
        if (phys) begin
            e.ok = 1; e.pa = va; e.perm = 3'b111; return;
        end
        if (va[63:43] != {21{va[63]}}) return;
        if (va[63] && va[42:41] == 2'b10) begin
            if (!priv) begin
                e.ok = 1; e.perm = 3'b111;
                e.pa = {20'h0, va[40], 3'b000, va[39:0]};
            end
            return;
        end
        tb = base;
        for (int l = 0; l < 3; l++) begin
            pte = rd(tb + 64'(va[13 + 10*(2-l) +: 10]) * 8);
            n++;
            if (!pte[0]) begin e.fault = 3'd0; return; end
            if (l < 2) begin
                if (!pte[8]) begin e.fault = 3'd1; return; end
                tb = 64'(pte[63:32]) << 13;
            end
        end
        g = {pte[8+priv], pte[12+priv], pte[8+priv]};
        if (need != 0 && (g & need) == 0) begin e.fault = 3'd1; return; end
        k = g & ~pte[3:1];
        if (need != 0 && (k & need) == 0) begin
            e.fault = need[2] ? 3'd3 : need[1] ? 3'd4 : 3'd2;
            return;
        end
        e.ok = 1; e.perm = k;
        e.pa = (64'(pte[63:32]) << 13) | {51'h0, va[12:0]};
    endtask

    task automatic tables(input logic [63:0] va, input logic [63:0] base,
                          input logic [63:0] l1, input logic [63:0] l2, input logic [63:0] l3);
        logic [63:0] b2, b3;
        mem.delete();
        mem[base + 64'(va[42:33]) * 8] = l1;
        b2 = 64'(l1[63:32]) << 13;
        mem[b2 + 64'(va[32:23]) * 8] = l2;
        b3 = 64'(l2[63:32]) << 13;
        mem[b3 + 64'(va[22:13]) * 8] = l3;
    endtask

    task automatic run(input logic [63:0] va, input logic [2:0] need, input logic priv,
                       input logic phys, input logic [63:0] base, input string tag,
                       input bit poke = 0);
        exp_t e; int n, r0, s0;
        model(va, need, priv, phys, base, e, n);
        e.tag = tag;
        exp_q.push_back(e);
        r0 = reads; s0 = seen;
        @(negedge clk);
        vaddr_i = va; acc_i = need; priv_i = priv; phys_i = phys; table_base_i = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            while (!mem_rsp_valid_i) @(negedge clk);
            // new start in the same cycle as a response: must be dropped
            phys_i = 1'b1; vaddr_i = 64'hDEAD_0000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; phys_i = 1'b0;
        end
        while (seen == s0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(seen == s0 + 1, tag, "done count", 64'(seen - s0), 64'h1);
        check(reads - r0 == n, tag, "table reads", 64'(reads - r0), 64'(n));
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] va_p, va_n, base, l1, l2;
        va_p = 64'h0000_0123_4567_89AB;
        va_n = 64'hFFFF_F812_3456_7890;
        base = 64'h0001_0000;
        l1 = {32'h20, 32'h0} | V | KR;
        l2 = {32'h30, 32'h0} | V | KR;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !mem_req_valid_o && !busy_o, "R10", "reset idle",
              {61'h0, done_o, mem_req_valid_o, busy_o}, 64'h0);

        tables(va_p, base, l1, l2, {32'h4_5678, 32'h0} | V | KR | KW);
        run(va_p, 3'b001, 0, 1, base, "R1");
        run(64'h0000_1000_0000_0000, 3'b001, 0, 0, base, "R2");
        run(64'hFFFF_FD12_3456_789A, 3'b100, 0, 0, base, "R3");
        run(64'hFFFF_FD12_3456_789A, 3'b001, 1, 0, base, "R3");
        run(va_p, 3'b001, 0, 0, base, "R4");
        run(va_p, 3'b011, 0, 0, base, "R9");
        run(va_p, 3'b000, 1, 0, base, "R9");

        tables(va_n, base, l1, l2, {32'h7_0001, 32'h0} | V | UR | UW);
        run(va_n, 3'b010, 1, 0, base, "R7");
        run(va_n, 3'b010, 0, 0, base, "R7");

        tables(va_p, base, l1 & ~V, l2, 64'h0);
        run(va_p, 3'b001, 0, 0, base, "R5");
        tables(va_p, base, l1, l2 & ~KR, 64'h0);
        run(va_p, 3'b001, 0, 0, base, "R5");
        tables(va_p, base, l1, l2, {32'h1, 32'h0} | KR);
        run(va_p, 3'b001, 0, 0, base, "R6");

        tables(va_p, base, l1, l2, {32'h9, 32'h0} | V | KR | KW | FE | FW);
        run(va_p, 3'b110, 0, 0, base, "R8");
        run(va_p, 3'b010, 0, 0, base, "R8");
        run(va_p, 3'b001, 0, 0, base, "R8");
        tables(va_p, base, l1, l2, {32'h9, 32'h0} | V | KR | KW | FR);
        run(va_p, 3'b001, 0, 0, base, "R8");
        run(va_p, 3'b101, 0, 0, base, "R8");

        tables(va_p, base, l1, l2, {32'h4_5678, 32'h0} | V | KR);
        run(va_p, 3'b001, 0, 0, base, "R10", 1);

        check(exp_q.size() == 0, "R10", "scoreboard empty", 64'(exp_q.size()), 64'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule